// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the operand store of a pipelined processor core. Every clock cycle it serves two source-operand reads and one result write. The cycle is modelled as two phases. In the first phase, both read ports look up their registers combinationally from the stored state. In the second phase, the write commits at the rising clock edge. Because of this order, a read that targets the register being written in the same cycle returns the value held before the write. No forwarding path is involved.

Register index zero is hardwired to zero: it always reads as zero, and writes to it are dropped. The register count and data width are parameters, and the defaults are 32 registers of 32 bits. An active-low asynchronous reset clears every register.

Top module: `rf_2r1w`

## Requirements
- R1: While reset is asserted, and directly after it is released, every register reads as zero on both ports.
- R2: Read port A returns, within the same cycle, the stored value of the register selected by `raddr_a_i`, combinationally from the address.
- R3: Read port B behaves like port A and is fully independent of it: both ports may select the same register or different registers in the same cycle.
- R4: When `we_i` is 1 and `waddr_i` is nonzero, the selected register holds `wdata_i` after the rising clock edge, and both ports return that value from the next cycle on.
- R5: When a read address equals the write address in a cycle where a write is enabled, that read returns the value held before that cycle's write.
- R6: Address 0 always reads as zero on both ports, and a write to address 0 changes no register.
- R7: When `we_i` is 0, no register changes, whatever values `waddr_i` and `wdata_i` carry.
- R8: Reading does not disturb stored state: repeated reads of one register return the same value until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears all registers |
| raddr_a_i | input | 5 | Read port A register index |
| rdata_a_o | output | 32 | Read port A data |
| raddr_b_i | input | 5 | Read port B register index |
| rdata_b_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write register index |
| wdata_i | input | 32 | Write data |

## Verification
A reference array is updated only after each cycle's reads have been compared. This alone separates read-before-write ordering from write-through forwarding on random traffic.

Directed patterns cover several cases, and each one isolates a single fault:
- A sweep after reset catches registers that reset wrongly.
- Writes to index zero catch a register 0 that is not hardwired.
- Cycles with the enable low and busy address and data lines catch writes that ignore the enable.
- Forced same-address collisions on both ports at once catch wrong read/write ordering on either port.
- Held read addresses across idle cycles catch reads that disturb stored state.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DEPTH_DEF = 32;
  localparam int unsigned RF_WIDTH_DEF = 32;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   waddr_i,
  output logic [NUM_REGS-1:0] wr_sel_o
);
  // index 0 never selected: hardwired zero register
  always_comb begin
    wr_sel_o = '0;
    for (int i = 1; i < NUM_REGS; i++)
      wr_sel_o[i] = we_i && (waddr_i == ADDR_W'(i));
  end

  assert_sel_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
  assert_idle_no_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> (wr_sel_o == '0));
  assert_zero_never_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waddr_i == '0) |-> (wr_sel_o == '0));
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              wr_sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  assign regs_o[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (wr_sel_i[g]) q <= wdata_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  input  logic [ADDR_W-1:0]                raddr_i,
  output logic [DATA_W-1:0]                rdata_o
);
  // read phase: pure mux on current state, ahead of the edge-committed write
  assign rdata_o = regs_i[raddr_i];

  assert_zero_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_i == '0) |-> (rdata_o == '0));
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = RF_DEPTH_DEF,
  parameter int unsigned DATA_W   = RF_WIDTH_DEF,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NUM_RD  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][ADDR_W-1:0]   raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;

  assign raddr[0]  = raddr_a_i;
  assign raddr[1]  = raddr_b_i;
  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wr_sel_o(wr_sel)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .wr_sel_i(wr_sel), .wdata_i, .regs_o(regs)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .clk_i, .rst_ni, .regs_i(regs), .raddr_i(raddr[p]), .rdata_o(rdata[p])
    );
  end

  assert_write_lands_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=>
      (raddr_a_i != $past(waddr_i)) || (rdata_a_o == $past(wdata_i)));
  assert_idle_hold_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (raddr_a_i != $past(raddr_a_i)) || $stable(rdata_a_o));
  assert_idle_hold_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (raddr_b_i != $past(raddr_b_i)) || $stable(rdata_b_o));
  assert_ports_agree_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == raddr_b_i) |-> (rdata_a_o == rdata_b_o));
endmodule

// File: tb/rf_2r1w_bench.sv
module rf_2r1w_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ra, rb, wa;
  logic [31:0] da, db, wd;
  logic        we;
  logic [31:0] ref_mem [NREG];
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_2r1w u_rf_2r1w (
    .clk_i(clk), .rst_ni(rst_n),
    .raddr_a_i(ra), .rdata_a_o(da),
    .raddr_b_i(rb), .rdata_b_o(db),
    .we_i(we), .waddr_i(wa), .wdata_i(wd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_for(logic [4:0] r);
    if (r == 0) return "R6";
    if (we && wa == r) return "R5";
    return "R2/R3";
  endfunction

  // one cycle: drive at negedge, compare pre-write state, then model the write
  task automatic cycle(logic [4:0] a, logic [4:0] b, logic w, logic [4:0] w_a, logic [31:0] w_d);
    @(negedge clk);
    ra = a; rb = b; we = w; wa = w_a; wd = w_d;
    #1;
    chk(tag_for(a), da, ref_mem[a]);
    chk(tag_for(b), db, ref_mem[b]);
    @(posedge clk);
    if (w && w_a != 0) ref_mem[w_a] = w_d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) ref_mem[i] = '0;
    ra = 0; rb = 0; we = 0; wa = 0; wd = 0;
    #(CLK_PERIOD*2 + 3);
    // R1: zero during reset
    ra = 5'd17; rb = 5'd31; #1;
    chk("R1", da, 0); chk("R1", db, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); ra = i[4:0]; rb = 5'(NREG-1-i); #1;
      chk("R1", da, 0); chk("R1", db, 0);
    end
    // R4: write then read back next cycle on both ports
    cycle(5'd3, 5'd4, 1'b1, 5'd3, 32'hDEADBEEF);
    cycle(5'd3, 5'd3, 1'b0, 5'd0, 32'h0);
    @(negedge clk); ra = 5'd3; rb = 5'd3; #1;
    chk("R4", da, 32'hDEADBEEF); chk("R4", db, 32'hDEADBEEF);
    // R5: collision on both ports returns the old value
    cycle(5'd3, 5'd3, 1'b1, 5'd3, 32'h12345678);
    @(negedge clk); we = 0; #1;
    chk("R5", da, 32'h12345678);
    // R6: write to zero ignored
    cycle(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFFFFFF);
    @(negedge clk); ra = 0; rb = 0; we = 0; #1;
    chk("R6", da, 0); chk("R6", db, 0);
    // R7: enable low with busy lines
    for (int i = 0; i < 8; i++) cycle(5'd3, 5'd3, 1'b0, 5'd3, $urandom);
    @(negedge clk); ra = 5'd3; we = 0; #1;
    chk("R7", da, 32'h12345678);
    // R8: repeated reads leave state unchanged
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ra = 5'd3; rb = 5'd3; we = 0; #1;
      chk("R8", da, 32'h12345678); chk("R8", db, 32'h12345678);
    end
    // random traffic with forced collisions
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a, b, w_a;
      a = 5'($urandom); b = 5'($urandom); w_a = 5'($urandom);
      if (($urandom % 4) == 0) w_a = a;
      if (($urandom % 4) == 0) b = w_a;
      cycle(a, b, ($urandom % 3) != 0, w_a, $urandom);
    end
    // final sweep against the reference
    for (int i = 0; i < NREG; i++) cycle(i[4:0], 5'(NREG-1-i), 1'b0, 5'd0, 32'h0);
    finish_run();
  end
endmodule